// File: doc/BRIEF.md
# Floppy controller host register file

This block is the processor-facing side of a floppy disk controller. A host reaches five byte-wide registers through active-low chip select, read and write strobes, a two-bit register address and separate byte-wide input and output data paths. The registers are status, command, track, sector and data. The block raises a data request for each byte the disk side moves and an interrupt request when a command finishes. It flags lost data when the host falls behind the disk side, in either direction. It also applies the master-reset defaults and starts a restore command when reset is released.

The disk-side engine is not part of this block. It appears only as strobes: a byte-assembled strobe with its byte, a byte-needed strobe, a command-done strobe, a busy level, a transfer-phase level and the engine's own status flags. In the other direction the block offers the command byte, a one-cycle command start pulse, and the track and sector values. For each byte the disk side asks for, it also supplies the byte to write.

All inputs are sampled on the rising clock edge. A host access is recognised when its strobe is released while chip select is still low.

Top module: `fdcHostRegs`

## Requirements
- R1: Register address 2'b01 selects track, 2'b10 selects sector and 2'b11 selects data, for both reads and writes. A write takes effect at the first clock edge where `weN` is sampled high after a cycle in which `csN` and `weN` were both low, provided `csN` is still low at that edge. The address and data stored are those of the last cycle in which both strobes were low.
- R2: `rdDataEn` is high, and `rdData` shows the register chosen by the current `addr`, only while `csN` and `reN` are both low; otherwise `rdData` is zero. Reading address 2'b00 returns status, never the command byte. Writing address 2'b00 goes to the command register and never changes status.
- R3: While `rstN` is low, the command register holds 0x03, sector holds 0x01, and track, data, `drq`, `intrq`, lost data and `cmdStart` are all zero. After the first clock edge with `rstN` high, `cmdStart` is high for exactly one cycle. This restore start does not depend on `engineBusy`.
- R4: `intrq` goes high the cycle after `cmdDone`. It is cleared when a status read completes (the same release rule as R1, with `reN`) or when a command write is accepted. A `cmdDone` in the same cycle wins.
- R5: `byteReady` copies `byteIn` into the data register and sets `drq`. A completed host read of the data register clears `drq`.
- R6: If `byteReady` arrives while `drq` is still set, and no host data access completes in that cycle, the lost-data flag is set. An accepted command write clears the flag.
- R7: On `byteNeeded` with `drq` clear, `byteOut` equals the data register in that cycle, and `drq` is set. A completed host write of the data register clears `drq`.
- R8: On `byteNeeded` while `drq` is still set, `byteOut` is 0x00 and the lost-data flag is set.
- R9: The status byte is built as follows. Bit 0 is `engineBusy`. Bits 7..3 are `engStatus[7:3]`. While `xferMode` is high, bit 2 is the lost-data flag and bit 1 is `drq`. While `xferMode` is low, bits 2 and 1 come from `engStatus`.
- R10: A command write is accepted when `engineBusy` is low, or when its upper nibble is 4'hD. An accepted write updates `cmdOut` and pulses `cmdStart` in the next cycle. Any other command write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Master reset, active low, asynchronous |
| csN | input | 1 | Chip select, active low |
| reN | input | 1 | Read strobe, active low |
| weN | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| wrData | input | 8 | Byte written by the host |
| rdData | output | 8 | Byte read by the host, zero when not driven |
| rdDataEn | output | 1 | Output-enable for the host data bus |
| engineBusy | input | 1 | Disk engine is executing a command |
| xferMode | input | 1 | Engine is in a read or write transfer phase |
| engStatus | input | 7 | Engine status flags for status bits 7..1 |
| byteReady | input | 1 | Engine assembled a byte from disk |
| byteIn | input | 8 | The assembled byte |
| byteNeeded | input | 1 | Engine needs the next byte to write |
| byteOut | output | 8 | Byte to write, valid with byteNeeded |
| cmdDone | input | 1 | Engine finished a command |
| drq | output | 1 | Data request |
| intrq | output | 1 | Interrupt request |
| cmdOut | output | 8 | Current command byte |
| cmdStart | output | 1 | One-cycle command start pulse |
| trackOut | output | 8 | Track register |
| sectorOut | output | 8 | Sector register |

## Verification
Most internal state reaches a port one cycle after it changes. A wrong drq or intrq flag is visible in the next cycle. A wrong register value shows on `trackOut`, `sectorOut` or `cmdOut` at once, or on `rdData` at the next host read. A wrong lost-data flag is hidden until status is read during a transfer phase. A wrongly armed strobe shows up as a register that changes one edge early or late, or not at all. Because of this, the bench compares every output against its reference on every cycle.

// File: rtl/fdcHostPkg.sv
package fdcHostPkg;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_CMDSTAT = 2'b00;
  localparam logic [SEL_W-1:0] SEL_TRACK   = 2'b01;
  localparam logic [SEL_W-1:0] SEL_SECTOR  = 2'b10;
  localparam logic [SEL_W-1:0] SEL_DATA    = 2'b11;

  localparam logic [3:0] FORCE_NIBBLE = 4'hD;

  // Completed host accesses, one strobe per register action.
  typedef struct packed {
    logic cmdWr;
    logic trkWr;
    logic secWr;
    logic datWr;
    logic statRd;
    logic datRd;
  } hostOps_t;

endpackage

// File: rtl/fdcHostCtrl.sv
module fdcHostCtrl
  import fdcHostPkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 reN,
  input  logic                 weN,
  input  logic [SEL_W-1:0]     addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 engineBusy,
  output hostOps_t             ops,
  output logic [DATA_W-1:0]    capData,
  output logic                 cmdStart
);

  logic               weArmed;
  logic               reArmed;
  logic [SEL_W-1:0]   wrAddrQ;
  logic [SEL_W-1:0]   rdAddrQ;
  logic [DATA_W-1:0]  wrDataQ;
  logic               kickQ;
  logic               startQ;
  logic               wrDone;
  logic               rdDone;
  logic               forceCmd;
  logic               wrLow;
  logic               rdLow;

  assign wrLow = !csN && !weN;
  assign rdLow = !csN && !reN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weArmed <= 1'b0;
      reArmed <= 1'b0;
      wrAddrQ <= '0;
      rdAddrQ <= '0;
      wrDataQ <= '0;
      kickQ   <= 1'b1;
      startQ  <= 1'b0;
    end else begin
      weArmed <= wrLow;
      reArmed <= rdLow;
      if (wrLow) begin
        wrAddrQ <= addr;
        wrDataQ <= wrData;
      end
      if (rdLow) begin
        rdAddrQ <= addr;
      end
      kickQ  <= 1'b0;
      startQ <= kickQ || ops.cmdWr;
    end
  end

  assign wrDone   = weArmed && weN && !csN;
  assign rdDone   = reArmed && reN && !csN;
  assign forceCmd = (wrDataQ[DATA_W-1 -: 4] == FORCE_NIBBLE);

  always_comb begin
    ops        = '0;
    ops.cmdWr  = wrDone && (wrAddrQ == SEL_CMDSTAT) && (!engineBusy || forceCmd);
    ops.trkWr  = wrDone && (wrAddrQ == SEL_TRACK);
    ops.secWr  = wrDone && (wrAddrQ == SEL_SECTOR);
    ops.datWr  = wrDone && (wrAddrQ == SEL_DATA);
    ops.statRd = rdDone && (rdAddrQ == SEL_CMDSTAT);
    ops.datRd  = rdDone && (rdAddrQ == SEL_DATA);
  end

  assign capData  = wrDataQ;
  assign cmdStart = startQ;

endmodule

// File: rtl/fdcHostData.sv
module fdcHostData
  import fdcHostPkg::*;
#(
  parameter int                 DATA_W  = BYTE_W,
  parameter logic [DATA_W-1:0]  CMD_RST = 8'h03,
  parameter logic [DATA_W-1:0]  SEC_RST = 8'h01
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hostOps_t             ops,
  input  logic [DATA_W-1:0]    capData,
  input  logic                 rdEn,
  input  logic [SEL_W-1:0]     addr,
  input  logic                 engineBusy,
  input  logic                 xferMode,
  input  logic [DATA_W-1:1]    engStatus,
  input  logic                 byteReady,
  input  logic [DATA_W-1:0]    byteIn,
  input  logic                 byteNeeded,
  input  logic                 cmdDone,
  output logic [DATA_W-1:0]    rdData,
  output logic [DATA_W-1:0]    byteOut,
  output logic                 drq,
  output logic                 intrq,
  output logic                 lostData,
  output logic [DATA_W-1:0]    cmdOut,
  output logic [DATA_W-1:0]    trackOut,
  output logic [DATA_W-1:0]    sectorOut
);

  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] trkReg;
  logic [DATA_W-1:0] secReg;
  logic [DATA_W-1:0] datReg;
  logic              drqQ;
  logic              lostQ;
  logic              intQ;
  logic              drqAfterHost;
  logic [DATA_W-1:0] datAfterHost;
  logic              diskEvent;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] selWord;

  // Host access in a cycle is ordered before the disk-side strobe.
  assign drqAfterHost = drqQ && !(ops.datRd || ops.datWr);
  assign datAfterHost = ops.datWr ? capData : datReg;
  assign diskEvent    = byteReady || byteNeeded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= CMD_RST;
      trkReg <= '0;
      secReg <= SEC_RST;
      datReg <= '0;
      drqQ   <= 1'b0;
      lostQ  <= 1'b0;
      intQ   <= 1'b0;
    end else begin
      if (ops.cmdWr) cmdReg <= capData;
      if (ops.trkWr) trkReg <= capData;
      if (ops.secWr) secReg <= capData;
      datReg <= byteReady ? byteIn : datAfterHost;
      drqQ   <= drqAfterHost || diskEvent;
      if (diskEvent && drqAfterHost) begin
        lostQ <= 1'b1;
      end else if (ops.cmdWr) begin
        lostQ <= 1'b0;
      end
      if (cmdDone) begin
        intQ <= 1'b1;
      end else if (ops.statRd || ops.cmdWr) begin
        intQ <= 1'b0;
      end
    end
  end

  always_comb begin
    statusWord                  = '0;
    statusWord[DATA_W-1:3]      = engStatus[DATA_W-1:3];
    statusWord[2]               = xferMode ? lostQ : engStatus[2];
    statusWord[1]               = xferMode ? drqQ  : engStatus[1];
    statusWord[0]               = engineBusy;
  end

  always_comb begin
    case (addr)
      SEL_TRACK:  selWord = trkReg;
      SEL_SECTOR: selWord = secReg;
      SEL_DATA:   selWord = datReg;
      default:    selWord = statusWord;
    endcase
  end

  assign rdData    = rdEn ? selWord : '0;
  assign byteOut   = drqAfterHost ? '0 : datAfterHost;
  assign drq       = drqQ;
  assign intrq     = intQ;
  assign lostData  = lostQ;
  assign cmdOut    = cmdReg;
  assign trackOut  = trkReg;
  assign sectorOut = secReg;

endmodule

// File: rtl/fdcHostRegs.sv
module fdcHostRegs
  import fdcHostPkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               reN,
  input  logic               weN,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdDataEn,
  input  logic               engineBusy,
  input  logic               xferMode,
  input  logic [DATA_W-1:1]  engStatus,
  input  logic               byteReady,
  input  logic [DATA_W-1:0]  byteIn,
  input  logic               byteNeeded,
  output logic [DATA_W-1:0]  byteOut,
  input  logic               cmdDone,
  output logic               drq,
  output logic               intrq,
  output logic [DATA_W-1:0]  cmdOut,
  output logic               cmdStart,
  output logic [DATA_W-1:0]  trackOut,
  output logic [DATA_W-1:0]  sectorOut
);

  hostOps_t          hostOps;
  logic [DATA_W-1:0] capData;
  logic              lostFlag;

  assign rdDataEn = !csN && !reN;

  fdcHostCtrl #(.DATA_W(DATA_W)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .reN        (reN),
    .weN        (weN),
    .addr       (addr),
    .wrData     (wrData),
    .engineBusy (engineBusy),
    .ops        (hostOps),
    .capData    (capData),
    .cmdStart   (cmdStart)
  );

  fdcHostData #(.DATA_W(DATA_W)) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ops        (hostOps),
    .capData    (capData),
    .rdEn       (rdDataEn),
    .addr       (addr),
    .engineBusy (engineBusy),
    .xferMode   (xferMode),
    .engStatus  (engStatus),
    .byteReady  (byteReady),
    .byteIn     (byteIn),
    .byteNeeded (byteNeeded),
    .cmdDone    (cmdDone),
    .rdData     (rdData),
    .byteOut    (byteOut),
    .drq        (drq),
    .intrq      (intrq),
    .lostData   (lostFlag),
    .cmdOut     (cmdOut),
    .trackOut   (trackOut),
    .sectorOut  (sectorOut)
  );

endmodule

// File: rtl/fdcHostRegs_chk.sv
module fdcHostRegs_chk
  import fdcHostPkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               csN,
  input logic               reN,
  input logic               byteReady,
  input logic               byteNeeded,
  input logic               cmdDone,
  input logic               drq,
  input logic               intrq,
  input logic [DATA_W-1:0]  rdData,
  input logic               rdDataEn,
  input logic [DATA_W-1:0]  cmdOut,
  input logic               cmdStart,
  input hostOps_t           ops,
  input logic               lostData
);

  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (csN || reN) |-> (!rdDataEn && rdData == '0)); // R2

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart); // R3

  AST_INT_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> intrq); // R4

  AST_INT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (ops.statRd && !cmdDone) |=> !intrq); // R4

  AST_DRQ_ON_DISK: assert property (@(posedge clk) disable iff (!rstN)
    (byteReady || byteNeeded) |=> drq); // R5

  AST_OVERRUN_LOST: assert property (@(posedge clk) disable iff (!rstN)
    (byteReady && drq && !ops.datRd && !ops.datWr) |=> lostData); // R6

  AST_UNDERRUN_LOST: assert property (@(posedge clk) disable iff (!rstN)
    (byteNeeded && drq && !ops.datRd && !ops.datWr) |=> lostData); // R8

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ops.cmdWr |=> $stable(cmdOut)); // R10

endmodule

bind fdcHostRegs fdcHostRegs_chk #(.DATA_W(DATA_W)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .reN        (reN),
  .byteReady  (byteReady),
  .byteNeeded (byteNeeded),
  .cmdDone    (cmdDone),
  .drq        (drq),
  .intrq      (intrq),
  .rdData     (rdData),
  .rdDataEn   (rdDataEn),
  .cmdOut     (cmdOut),
  .cmdStart   (cmdStart),
  .ops        (hostOps),
  .lostData   (lostFlag)
);

// File: tb/fdcHostRegs_test.sv
module fdcHostRegs_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, reN = 1'b1, weN = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic       engineBusy = 1'b0, xferMode = 1'b0;
  logic [7:1] engStatus = 7'h00;
  logic       byteReady = 1'b0, byteNeeded = 1'b0, cmdDone = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic [7:0] rdData, byteOut, cmdOut, trackOut, sectorOut;
  logic       rdDataEn, drq, intrq, cmdStart;

  always #2 clk = ~clk;

  fdcHostRegs uut (
    .clk(clk), .rstN(rstN), .csN(csN), .reN(reN), .weN(weN), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdDataEn(rdDataEn),
    .engineBusy(engineBusy), .xferMode(xferMode), .engStatus(engStatus),
    .byteReady(byteReady), .byteIn(byteIn), .byteNeeded(byteNeeded),
    .byteOut(byteOut), .cmdDone(cmdDone), .drq(drq), .intrq(intrq),
    .cmdOut(cmdOut), .cmdStart(cmdStart), .trackOut(trackOut),
    .sectorOut(sectorOut)
  );

  int    nCompared = 0;
  int    nMismatch = 0;
  bit    finished  = 1'b0;
  string curReq    = "R3";

  // Reference state
  int   rCmd, rTrk, rSec, rDat;
  bit   rDrq, rLost, rInt, rKick, rStart;
  bit   pendWr, pendRd;
  int   pendWrAddr, pendWrData, pendRdAddr;

  task automatic resetModel();
    rCmd = 8'h03; rTrk = 0; rSec = 8'h01; rDat = 0;
    rDrq = 0; rLost = 0; rInt = 0; rKick = 1; rStart = 0;
    pendWr = 0; pendRd = 0; pendWrAddr = 0; pendWrData = 0; pendRdAddr = 0;
  endtask

  function automatic bit wrFinishes();
    return pendWr && weN && !csN;
  endfunction

  function automatic bit rdFinishes();
    return pendRd && reN && !csN;
  endfunction

  function automatic bit drqAfterHostAccess();
    bit touched;
    touched = (wrFinishes() && pendWrAddr == 3) || (rdFinishes() && pendRdAddr == 3);
    return rDrq && !touched;
  endfunction

  function automatic int statusByte();
    int s;
    s = {engStatus[7:3], 3'b000};
    s[2] = xferMode ? rLost : engStatus[2];
    s[1] = xferMode ? rDrq  : engStatus[1];
    s[0] = engineBusy;
    return s;
  endfunction

  function automatic int expectRead();
    if (csN || reN) return 0;
    case (addr)
      2'b01: return rTrk;
      2'b10: return rSec;
      2'b11: return rDat;
      default: return statusByte();
    endcase
  endfunction

  function automatic int expectByteOut();
    if (drqAfterHostAccess()) return 0;
    if (wrFinishes() && pendWrAddr == 3) return pendWrData;
    return rDat;
  endfunction

  task automatic modelEdge();
    bit w, r, acc, hostDat, dEvt, dq;
    if (!rstN) begin resetModel(); return; end
    w = wrFinishes(); r = rdFinishes();
    acc = w && pendWrAddr == 0 && (!engineBusy || pendWrData[7:4] == 4'hD);
    dq = drqAfterHostAccess();
    dEvt = byteReady || byteNeeded;
    hostDat = w && pendWrAddr == 3;
    rStart = rKick || acc;
    rKick = 0;
    if (acc) rCmd = pendWrData;
    if (w && pendWrAddr == 1) rTrk = pendWrData;
    if (w && pendWrAddr == 2) rSec = pendWrData;
    if (hostDat) rDat = pendWrData;
    if (byteReady) rDat = byteIn;
    if (acc) rLost = 0;
    if (dEvt && dq) rLost = 1;
    rDrq = dq || dEvt;
    if (acc || (r && pendRdAddr == 0)) rInt = 0;
    if (cmdDone) rInt = 1;
    pendWr = !csN && !weN;
    if (pendWr) begin pendWrAddr = addr; pendWrData = wrData; end
    pendRd = !csN && !reN;
    if (pendRd) pendRdAddr = addr;
  endtask

  task automatic cmp(string name, string req, int act, int exp);
    nCompared++;
    if (act != exp) begin
      nMismatch++;
      $display("FAIL %s (%s) %s: actual %02h expected %02h at %0t",
               curReq, req, name, act, exp, $time);
    end
  endtask

  // Called at a falling edge with inputs already applied.
  task automatic tick();
    if (!rstN) resetModel();
    #1;
    cmp("rdDataEn", "R2", rdDataEn, (!csN && !reN));
    cmp("rdData", (addr == 0) ? "R9" : "R1", rdData, expectRead());
    cmp("drq", "R5", drq, rDrq);
    cmp("intrq", "R4", intrq, rInt);
    cmp("cmdOut", "R10", cmdOut, rCmd);
    cmp("cmdStart", "R3", cmdStart, rStart);
    cmp("trackOut", "R1", trackOut, rTrk);
    cmp("sectorOut", "R1", sectorOut, rSec);
    if (byteNeeded) cmp("byteOut", drqAfterHostAccess() ? "R8" : "R7", byteOut, expectByteOut());
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic hostWrite(logic [1:0] a, logic [7:0] d);
    csN = 0; weN = 0; addr = a; wrData = d; tick();
    weN = 1; wrData = ~d; tick();
    csN = 1;
  endtask

  task automatic hostRead(logic [1:0] a);
    csN = 0; reN = 0; addr = a; tick();
    reN = 1; tick();
    csN = 1;
  endtask

  task automatic diskByte(logic [7:0] b);
    byteReady = 1; byteIn = b; tick();
    byteReady = 0;
  endtask

  task automatic diskNeed();
    byteNeeded = 1; tick();
    byteNeeded = 0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nCompared++; nMismatch++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    resetModel();
    @(negedge clk);
    // R3: defaults under reset, restore pulse after release
    curReq = "R3";
    idle(3);
    rstN = 1;
    idle(3);
    hostRead(2'b10);
    idle(1);

    // R1: track, sector and data registers through the host port
    curReq = "R1";
    hostWrite(2'b01, 8'h5A);
    hostWrite(2'b10, 8'h11);
    hostWrite(2'b11, 8'h77);
    idle(1);
    hostRead(2'b01);
    hostRead(2'b10);
    hostRead(2'b11);
    // write aborted by chip select rising with the strobe: no effect
    csN = 0; weN = 0; addr = 2'b01; wrData = 8'hEE; tick();
    csN = 1; weN = 1; tick();
    idle(1);

    // R2: no drive without chip select; address 0 reads status not command
    curReq = "R2";
    reN = 0; addr = 2'b01; tick(); reN = 1;
    hostWrite(2'b00, 8'h1C);
    idle(2);
    engStatus = 7'h00;
    hostRead(2'b00);
    idle(1);

    // R9: status composition with and without a transfer phase
    curReq = "R9";
    engStatus = 7'h56; engineBusy = 1;
    hostRead(2'b00);
    xferMode = 1;
    hostRead(2'b00);
    engineBusy = 0; xferMode = 0; engStatus = 7'h00;
    idle(1);

    // R4: interrupt set and cleared by status read or command write
    curReq = "R4";
    cmdDone = 1; tick(); cmdDone = 0;
    idle(1);
    hostRead(2'b00);
    idle(1);
    cmdDone = 1; tick(); cmdDone = 0;
    hostWrite(2'b00, 8'h20);
    idle(1);
    // completion and status read in the same cycle: interrupt stays set
    csN = 0; reN = 0; addr = 2'b00; tick();
    reN = 1; cmdDone = 1; tick();
    cmdDone = 0; csN = 1;
    idle(2);
    hostRead(2'b00);

    // R5 and R6: read transfer, data request and overrun
    curReq = "R5";
    xferMode = 1; engineBusy = 1;
    diskByte(8'h31);
    idle(1);
    hostRead(2'b11);
    idle(1);
    curReq = "R6";
    diskByte(8'h32);
    idle(1);
    diskByte(8'h33);
    idle(1);
    hostRead(2'b00);
    hostRead(2'b11);
    engineBusy = 0;
    hostWrite(2'b00, 8'hA0);
    idle(1);
    hostRead(2'b00);

    // R7 and R8: write transfer, handshake and underrun
    curReq = "R7";
    engineBusy = 1;
    hostWrite(2'b11, 8'hC3);
    diskNeed();
    idle(1);
    hostWrite(2'b11, 8'h3C);
    idle(1);
    diskNeed();
    idle(1);
    curReq = "R8";
    diskNeed();
    idle(1);
    hostRead(2'b00);
    xferMode = 0;

    // R10: command writes while busy
    curReq = "R10";
    hostWrite(2'b00, 8'h88);
    idle(2);
    hostWrite(2'b00, 8'hD4);
    idle(2);
    engineBusy = 0;
    hostWrite(2'b00, 8'h0B);
    idle(3);

    finishRun();
  end

endmodule